// File: doc/BRIEF.md
# HALT Mode Wake Controller

This block handles the CPU's low-power HALT state. The CPU core gives a single-cycle pulse when it has executed its halt instruction. The block then drops the CPU clock enable and leaves the oscillator and peripheral clock enables asserted. While halted, it watches a non-maskable request and eight maskable request lines. Each maskable line has a mask bit and a two-bit priority. The block also watches the global interrupt-enable state and the priority of any routine currently in service.

Waking and acknowledging are separate decisions. Any pending request whose line is unmasked ends HALT, whatever its priority. The block then issues a one-cycle wake pulse together with exactly one outcome:

- a non-maskable acknowledge;
- a maskable acknowledge carrying the line index of the winning request;
- a resume-at-next-instruction indication.

A maskable request that is not acknowledged keeps its pending flag, so it can be taken later.

Top module: `halt_wake_ctrl`

## Requirements
- R1: A one-cycle `halt_req_i` pulse while running makes `halted_o` read 1 after the next rising edge. A `halt_req_i` pulse while already halted has no effect: `halted_o` stays 1 and `wake_o` stays 0.
- R2: `osc_run_o` and `periph_clk_en_o` read 1 at all times, including during reset and HALT.
- R3: `cpu_clk_en_o` changes only on falling clock edges. It reads 1 out of reset, goes to 0 at the first falling edge after `halted_o` rises, and returns to 1 at the first falling edge after `halted_o` falls.
- R4: While halted, the block wakes only when the non-maskable pending flag is set or some maskable pending flag has its mask bit (`irq_mask_i`, 1 = masked) clear. A pending request on a masked line neither wakes the block nor loses its pending flag.
- R5: A wake is a single-cycle `wake_o` pulse, registered one rising edge after the wake condition is seen. In the same cycle exactly one of `nmi_ack_o`, `ack_o` or `resume_next_o` is 1, and `halted_o` reads 0.
- R6: A pending non-maskable request always wakes with `nmi_ack_o`, regardless of `int_en_i`, `in_service_i` or pending maskable requests. It clears only the non-maskable pending flag.
- R7: A maskable wake while `int_en_i` is 0 gives `resume_next_o`, and all maskable pending flags are kept.
- R8: With `int_en_i` 1 and `in_service_i` 1, a winning maskable request whose priority value is greater than or equal to `svc_prio_i` gives `resume_next_o`, and its pending flag is kept.
- R9: With `int_en_i` 1, a winning maskable request is acknowledged when either no routine is in service or its priority value is strictly less than `svc_prio_i`. The block then raises `ack_o`, puts the line number on `ack_idx_o`, and clears only that line's pending flag.
- R10: Among unmasked pending lines, the winner is the one with the numerically lowest priority (0 is the most urgent). Ties go to the lowest line index. Line i's priority is `irq_prio_i[2i+1:2i]`.
- R11: While `rst_n` is low at a rising edge, the block clears HALT, all pending flags and all wake outputs. `cpu_clk_en_o` becomes 1 at the following falling edge.
- R12: A high level on `irq_i[i]` or `nmi_i` at a rising edge sets the matching pending flag. The flag is visible on `pend_o` / `nmi_pend_o` and stays set until that request is acknowledged or the block is reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock from the oscillator |
| rst_n | input | 1 | Synchronous active-low reset |
| halt_req_i | input | 1 | Pulse from the CPU: halt instruction executed |
| nmi_i | input | 1 | Non-maskable request |
| irq_i | input | 8 | Maskable request lines |
| irq_mask_i | input | 8 | Mask bit per line, 1 blocks the line |
| irq_prio_i | input | 16 | Two-bit priority per line, 0 most urgent |
| int_en_i | input | 1 | Global maskable interrupt enable |
| in_service_i | input | 1 | A routine is in progress |
| svc_prio_i | input | 2 | Priority of the routine in progress |
| cpu_clk_en_o | output | 1 | Glitch-free CPU clock enable |
| periph_clk_en_o | output | 1 | Peripheral clock enable, always on |
| osc_run_o | output | 1 | Oscillator run enable, always on |
| halted_o | output | 1 | HALT state |
| wake_o | output | 1 | One-cycle wake pulse |
| nmi_ack_o | output | 1 | Wake acknowledges the non-maskable request |
| ack_o | output | 1 | Wake acknowledges a maskable request |
| ack_idx_o | output | 3 | Line number of the acknowledged request |
| resume_next_o | output | 1 | Wake resumes at the next instruction |
| pend_o | output | 8 | Maskable pending flags |
| nmi_pend_o | output | 1 | Non-maskable pending flag |

## Verification
The assertions assume that `halt_req_i` is a single-cycle pulse. They also assume that the mask, priority, enable and in-service inputs are stable from the cycle before a possible wake until the wake has been reported. The stimulus changes these inputs only while the block is running or before it issues a halt pulse. It pulses the request lines for a single cycle each, so every outcome depends only on the flags captured in the pending registers.

// File: rtl/hwk_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the HALT wake controller.
// Assumes: nothing; holds only the outcome encoding and default sizes.
package hwk_pkg;
    localparam int unsigned DEF_LINES  = 8;
    localparam int unsigned DEF_PRIO_W = 2;

    // Outcome chosen at the moment HALT ends.
    typedef enum logic [1:0] {
        WK_NONE   = 2'd0,
        WK_RESUME = 2'd1,
        WK_ACK    = 2'd2,
        WK_NMI    = 2'd3
    } wake_kind_e;
endpackage

// File: rtl/hwk_pending.sv
`timescale 1ns/1ps
// Bank of sticky pending flags, one per request line.
// Assumes: set and clear may coincide; a new set then wins so no request is lost.
module hwk_pending #(
    parameter int unsigned LINES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] set_i,
    input  logic [LINES-1:0] clr_i,
    output logic [LINES-1:0] pend_o
);
    for (genvar g = 0; g < LINES; g++) begin : g_flag
        logic flag_q;
        // Hold the flag from request until acknowledge or reset.
        always_ff @(posedge clk) begin
            if (!rst_n)        flag_q <= 1'b0;
            else if (set_i[g]) flag_q <= 1'b1;
            else if (clr_i[g]) flag_q <= 1'b0;
        end
        assign pend_o[g] = flag_q;
    end
endmodule

// File: rtl/hwk_arbiter.sv
`timescale 1ns/1ps
// Picks the most urgent candidate line: lowest priority value, then lowest index.
// Assumes: purely combinational; outputs are don't-care when any_o is 0.
module hwk_arbiter #(
    parameter int unsigned LINES  = 8,
    parameter int unsigned PRIO_W = 2,
    localparam int unsigned IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic [LINES-1:0]        req_i,
    input  logic [LINES*PRIO_W-1:0] prio_i,
    output logic                    any_o,
    output logic [IDX_W-1:0]        idx_o,
    output logic [PRIO_W-1:0]       prio_o
);
    // Linear scan; strict compare keeps the earlier (lower) index on ties.
    always_comb begin
        any_o  = 1'b0;
        idx_o  = '0;
        prio_o = '0;
        for (int i = 0; i < LINES; i++) begin
            if (req_i[i] && (!any_o || prio_i[i*PRIO_W +: PRIO_W] < prio_o)) begin
                any_o  = 1'b1;
                idx_o  = i[IDX_W-1:0];
                prio_o = prio_i[i*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/hwk_clkgate.sv
`timescale 1ns/1ps
// CPU clock enable register updated on the falling edge.
// Assumes: a downstream AND-gate clock gate passes the clock while en_o is 1;
// changing en_o only while clk is low keeps the gated clock free of runt pulses.
module hwk_clkgate (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic en_o
);
    // Capture the run request in the low phase of the clock.
    always_ff @(negedge clk) begin
        if (!rst_n) en_o <= 1'b1;
        else        en_o <= run_i;
    end
endmodule

// File: rtl/halt_wake_ctrl.sv
`timescale 1ns/1ps
// HALT mode wake controller.
// Enters HALT on the CPU's halt pulse and gates only the CPU clock. It leaves
// HALT on any pending non-maskable request or any unmasked maskable request,
// then reports either an acknowledge or a resume-next outcome.
// Assumes: halt_req_i is a one-cycle pulse; configuration inputs are quasi-static.
module halt_wake_ctrl
    import hwk_pkg::*;
#(
    parameter int unsigned LINES  = DEF_LINES,
    parameter int unsigned PRIO_W = DEF_PRIO_W,
    localparam int unsigned IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    halt_req_i,
    input  logic                    nmi_i,
    input  logic [LINES-1:0]        irq_i,
    input  logic [LINES-1:0]        irq_mask_i,
    input  logic [LINES*PRIO_W-1:0] irq_prio_i,
    input  logic                    int_en_i,
    input  logic                    in_service_i,
    input  logic [PRIO_W-1:0]       svc_prio_i,
    output logic                    cpu_clk_en_o,
    output logic                    periph_clk_en_o,
    output logic                    osc_run_o,
    output logic                    halted_o,
    output logic                    wake_o,
    output logic                    nmi_ack_o,
    output logic                    ack_o,
    output logic [IDX_W-1:0]        ack_idx_o,
    output logic                    resume_next_o,
    output logic [LINES-1:0]        pend_o,
    output logic                    nmi_pend_o
);
    logic               halted_q;
    wake_kind_e         kind_d, kind_q;
    logic [IDX_W-1:0]   idx_q;
    logic [LINES-1:0]   cand, clr_irq;
    logic               cand_any, wake_now, outranks;
    logic [IDX_W-1:0]   best_idx;
    logic [PRIO_W-1:0]  best_prio;

    hwk_pending #(.LINES(LINES)) u_irq_pend (
        .clk(clk), .rst_n(rst_n), .set_i(irq_i), .clr_i(clr_irq), .pend_o(pend_o)
    );

    hwk_pending #(.LINES(1)) u_nmi_pend (
        .clk(clk), .rst_n(rst_n), .set_i(nmi_i),
        .clr_i(kind_d == WK_NMI), .pend_o(nmi_pend_o)
    );

    assign cand = pend_o & ~irq_mask_i;

    hwk_arbiter #(.LINES(LINES), .PRIO_W(PRIO_W)) u_arb (
        .req_i(cand), .prio_i(irq_prio_i),
        .any_o(cand_any), .idx_o(best_idx), .prio_o(best_prio)
    );

    // Wake needs only an unmasked request; acknowledge also needs enable and rank.
    assign wake_now = halted_q && (nmi_pend_o || cand_any);
    assign outranks = !in_service_i || (best_prio < svc_prio_i);

    // Decide the outcome of this cycle's wake.
    always_comb begin
        if (!wake_now)                 kind_d = WK_NONE;
        else if (nmi_pend_o)           kind_d = WK_NMI;
        else if (int_en_i && outranks) kind_d = WK_ACK;
        else                           kind_d = WK_RESUME;
    end

    // Only an acknowledged maskable request loses its pending flag.
    assign clr_irq = (kind_d == WK_ACK) ? (LINES'(1) << best_idx) : '0;

    // HALT state and registered wake report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halted_q <= 1'b0;
            kind_q   <= WK_NONE;
            idx_q    <= '0;
        end else begin
            if (wake_now)        halted_q <= 1'b0;
            else if (halt_req_i) halted_q <= 1'b1;
            kind_q <= kind_d;
            idx_q  <= best_idx;
        end
    end

    hwk_clkgate u_gate (
        .clk(clk), .rst_n(rst_n), .run_i(!halted_q), .en_o(cpu_clk_en_o)
    );

    assign periph_clk_en_o = 1'b1;
    assign osc_run_o       = 1'b1;
    assign halted_o        = halted_q;
    assign wake_o          = (kind_q != WK_NONE);
    assign nmi_ack_o       = (kind_q == WK_NMI);
    assign ack_o           = (kind_q == WK_ACK);
    assign resume_next_o   = (kind_q == WK_RESUME);
    assign ack_idx_o       = idx_q;
endmodule

// File: rtl/halt_wake_ctrl_chk.sv
`timescale 1ns/1ps
// Property checker for halt_wake_ctrl, attached by bind.
// Assumes: halt_req_i pulses for one cycle; configuration is stable around a wake.
module halt_wake_ctrl_chk #(
    parameter int unsigned LINES  = 8,
    parameter int unsigned PRIO_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             halt_req_i,
    input logic [LINES-1:0] irq_mask_i,
    input logic             int_en_i,
    input logic             in_service_i,
    input logic             cpu_clk_en_o,
    input logic             halted_o,
    input logic             wake_o,
    input logic             nmi_ack_o,
    input logic             ack_o,
    input logic             resume_next_o,
    input logic [LINES-1:0] pend_o,
    input logic             nmi_pend_o
);
    // R1
    halt_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req_i && !halted_o |=> halted_o);

    // R3
    clk_en_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_clk_en_o == !halted_o);

    // R4
    masked_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted_o && !nmi_pend_o && ((pend_o & ~irq_mask_i) == '0) |=> halted_o && !wake_o);

    // R5
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> $countones({nmi_ack_o, ack_o, resume_next_o}) == 1 && !halted_o);

    // R5
    wake_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |=> !wake_o);

    // R6
    nmi_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted_o && nmi_pend_o |=> wake_o && nmi_ack_o);

    // R7
    disabled_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted_o && !nmi_pend_o && !int_en_i && ((pend_o & ~irq_mask_i) != '0)
        |=> resume_next_o && ($countones(pend_o) == $countones($past(pend_o))));

    // R9
    idle_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted_o && !nmi_pend_o && int_en_i && !in_service_i && ((pend_o & ~irq_mask_i) != '0)
        |=> ack_o);

    // R11
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> !halted_o && !wake_o && pend_o == '0 && !nmi_pend_o);
endmodule

bind halt_wake_ctrl halt_wake_ctrl_chk #(.LINES(LINES), .PRIO_W(PRIO_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .halt_req_i(halt_req_i), .irq_mask_i(irq_mask_i),
    .int_en_i(int_en_i), .in_service_i(in_service_i), .cpu_clk_en_o(cpu_clk_en_o),
    .halted_o(halted_o), .wake_o(wake_o), .nmi_ack_o(nmi_ack_o), .ack_o(ack_o),
    .resume_next_o(resume_next_o), .pend_o(pend_o), .nmi_pend_o(nmi_pend_o)
);

// File: tb/tb_halt_wake_ctrl.sv
`timescale 1ns/1ps
// Bench: a vector table walked by one loop, then directed corner cases.
module tb_halt_wake_ctrl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        halt_req_i, nmi_i, int_en_i, in_service_i;
    logic [7:0]  irq_i, irq_mask_i;
    logic [15:0] irq_prio_i;
    logic [1:0]  svc_prio_i;
    logic        cpu_clk_en_o, periph_clk_en_o, osc_run_o, halted_o, wake_o;
    logic        nmi_ack_o, ack_o, resume_next_o, nmi_pend_o;
    logic [2:0]  ack_idx_o;
    logic [7:0]  pend_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    halt_wake_ctrl dut (
        .clk(clk), .rst_n(rst_n), .halt_req_i(halt_req_i), .nmi_i(nmi_i),
        .irq_i(irq_i), .irq_mask_i(irq_mask_i), .irq_prio_i(irq_prio_i),
        .int_en_i(int_en_i), .in_service_i(in_service_i), .svc_prio_i(svc_prio_i),
        .cpu_clk_en_o(cpu_clk_en_o), .periph_clk_en_o(periph_clk_en_o),
        .osc_run_o(osc_run_o), .halted_o(halted_o), .wake_o(wake_o),
        .nmi_ack_o(nmi_ack_o), .ack_o(ack_o), .ack_idx_o(ack_idx_o),
        .resume_next_o(resume_next_o), .pend_o(pend_o), .nmi_pend_o(nmi_pend_o)
    );

    // Vector: mask, prio, en, svc, sprio, irq, nmi, kind, idx, pend after
    // kind: 0 resume, 1 maskable ack, 2 nmi ack, 3 stays halted
    localparam logic [15:0] PA = 16'h1B1B; // line prios 3,2,1,0,3,2,1,0
    localparam logic [15:0] PB = 16'h5555; // every line prio 1
    localparam logic [49:0] VEC [0:10] = '{
        {8'h00, PA, 1'b1, 1'b0, 2'd0, 8'h01, 1'b0, 2'd1, 3'd0, 8'h00}, // R9
        {8'h00, PA, 1'b1, 1'b0, 2'd0, 8'h88, 1'b0, 2'd1, 3'd3, 8'h80}, // R10 tie
        {8'h08, PA, 1'b1, 1'b0, 2'd0, 8'h8C, 1'b0, 2'd1, 3'd7, 8'h0C}, // R10 masked
        {8'h00, PB, 1'b1, 1'b0, 2'd0, 8'hF0, 1'b0, 2'd1, 3'd4, 8'hE0}, // R10 all tie
        {8'h00, PA, 1'b0, 1'b0, 2'd0, 8'h02, 1'b0, 2'd0, 3'd0, 8'h02}, // R7
        {8'h00, PA, 1'b1, 1'b1, 2'd1, 8'h04, 1'b0, 2'd0, 3'd0, 8'h04}, // R8 equal
        {8'h00, PA, 1'b1, 1'b1, 2'd1, 8'h08, 1'b0, 2'd1, 3'd3, 8'h00}, // R9 higher
        {8'h00, PA, 1'b1, 1'b1, 2'd0, 8'h10, 1'b0, 2'd0, 3'd0, 8'h10}, // R8 lower
        {8'h00, PA, 1'b0, 1'b1, 2'd0, 8'h01, 1'b1, 2'd2, 3'd0, 8'h01}, // R6
        {8'hFF, PA, 1'b1, 1'b0, 2'd0, 8'h21, 1'b0, 2'd3, 3'd0, 8'h21}, // R4
        {8'h00, PA, 1'b1, 1'b0, 2'd0, 8'h00, 1'b1, 2'd2, 3'd0, 8'h00}  // R6
    };

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
    endtask

    task automatic do_halt();
        halt_req_i = 1'b1;
        step();
        halt_req_i = 1'b0;
    endtask

    task automatic pulse_irq(input logic [7:0] lines, input logic nm);
        irq_i = lines;
        nmi_i = nm;
        step();
        irq_i = '0;
        nmi_i = 1'b0;
    endtask

    task automatic run_vec(input logic [49:0] v);
        do_reset();
        irq_mask_i   = v[49:42];
        irq_prio_i   = v[41:26];
        int_en_i     = v[25];
        in_service_i = v[24];
        svc_prio_i   = v[23:22];
        step();
        do_halt();
        chk("R1 halted", {31'd0, halted_o}, 32'd1);
        pulse_irq(v[21:14], v[13]);
        step();
        chk("R12 pend", {24'd0, pend_o}, {24'd0, v[7:0]});
        case (v[12:11])
            2'd3: begin
                chk("R4 still halted", {31'd0, halted_o}, 32'd1);
                chk("R4 no wake", {31'd0, wake_o}, 32'd0);
            end
            default: begin
                chk("R5 wake", {31'd0, wake_o}, 32'd1);
                chk("R5 halted cleared", {31'd0, halted_o}, 32'd0);
                chk("R6 nmi ack", {31'd0, nmi_ack_o}, {31'd0, v[12:11] == 2'd2});
                chk("R9 ack", {31'd0, ack_o}, {31'd0, v[12:11] == 2'd1});
                chk("R8 resume", {31'd0, resume_next_o}, {31'd0, v[12:11] == 2'd0});
                if (v[12:11] == 2'd1) chk("R10 index", {29'd0, ack_idx_o}, {29'd0, v[10:8]});
                if (v[12:11] == 2'd2) chk("R6 nmi pend cleared", {31'd0, nmi_pend_o}, 32'd0);
            end
        endcase
    endtask

    // Watchdog: a hung run counts as one failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; halt_req_i = 1'b0; nmi_i = 1'b0; irq_i = '0;
        irq_mask_i = '0; irq_prio_i = PA; int_en_i = 1'b1;
        in_service_i = 1'b0; svc_prio_i = '0;
        repeat (3) step();
        chk("R11 halted", {31'd0, halted_o}, 32'd0);
        chk("R11 pend", {24'd0, pend_o}, 32'd0);
        chk("R11 wake", {31'd0, wake_o}, 32'd0);
        chk("R11 cpu clk", {31'd0, cpu_clk_en_o}, 32'd1);
        chk("R2 periph", {31'd0, periph_clk_en_o}, 32'd1);
        chk("R2 osc", {31'd0, osc_run_o}, 32'd1);
        rst_n = 1'b1;
        step();

        for (int k = 0; k <= 10; k++) run_vec(VEC[k]);

        // R3: enable falls and rises only at falling edges
        do_reset();
        irq_mask_i = '0; irq_prio_i = PA; int_en_i = 1'b1; in_service_i = 1'b0;
        step();
        do_halt();
        chk("R3 enable before falling edge", {31'd0, cpu_clk_en_o}, 32'd1);
        @(negedge clk); #1;
        chk("R3 enable gated", {31'd0, cpu_clk_en_o}, 32'd0);
        chk("R2 periph in halt", {31'd0, periph_clk_en_o}, 32'd1);
        chk("R2 osc in halt", {31'd0, osc_run_o}, 32'd1);
        step();
        pulse_irq(8'h40, 1'b0);
        step();
        chk("R5 wake", {31'd0, wake_o}, 32'd1);
        chk("R3 enable still off", {31'd0, cpu_clk_en_o}, 32'd0);
        @(negedge clk); #1;
        chk("R3 enable restored", {31'd0, cpu_clk_en_o}, 32'd1);
        step();
        chk("R5 single pulse", {31'd0, wake_o}, 32'd0);

        // R1 repeated halt ignored; R4 masked request keeps sleeping
        do_reset();
        irq_mask_i = 8'hFF; int_en_i = 1'b1; in_service_i = 1'b0;
        pulse_irq(8'h01, 1'b0);
        do_halt();
        step();
        do_halt();
        chk("R1 repeat halt", {31'd0, halted_o}, 32'd1);
        chk("R1 no wake", {31'd0, wake_o}, 32'd0);
        chk("R4 pend kept", {24'd0, pend_o}, 32'h01);
        irq_mask_i = 8'h00;
        step();
        chk("R4 unmask wakes", {31'd0, wake_o & ack_o}, 32'd1);
        chk("R9 cleared", {24'd0, pend_o}, 32'h00);

        // R12 a request left pending after resume is taken on the next halt
        do_reset();
        irq_mask_i = '0; int_en_i = 1'b0; in_service_i = 1'b0;
        pulse_irq(8'h02, 1'b0);
        do_halt();
        step();
        chk("R7 resume", {31'd0, resume_next_o}, 32'd1);
        chk("R12 still pending", {24'd0, pend_o}, 32'h02);
        int_en_i = 1'b1;
        do_halt();
        step();
        chk("R12 later ack", {31'd0, ack_o}, 32'd1);
        chk("R12 ack index", {29'd0, ack_idx_o}, 32'd1);
        chk("R12 cleared", {24'd0, pend_o}, 32'h00);

        // R11 reset while halted
        do_reset();
        irq_mask_i = 8'hFF;
        pulse_irq(8'h10, 1'b0);
        do_halt();
        @(negedge clk); #1;
        chk("R11 gated before reset", {31'd0, cpu_clk_en_o}, 32'd0);
        rst_n = 1'b0;
        step();
        chk("R11 halt cleared", {31'd0, halted_o}, 32'd0);
        chk("R11 pend cleared", {24'd0, pend_o}, 32'h00);
        @(negedge clk); #1;
        chk("R11 enable restored", {31'd0, cpu_clk_en_o}, 32'd1);
        rst_n = 1'b1;
        step();

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule